// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block takes an asynchronous serial input and turns it into characters. It samples the line 16 times per bit, using enable ticks from an external baud generator. A frame is a low start bit, DATA_BITS data bits sent least significant bit first, an optional parity bit and a high stop bit. Each bit value comes from a two-of-three vote. The finished character goes into a data register that the CPU reads over a small register bus.

Three conditions are kept as sticky, read-only flags: noise, framing error and parity error. Each flag drives its own interrupt request through its own enable bit. A flag clears only after a two-step access: the CPU reads the status register while the flag is set, then reads the data register. Any error that occurs after that status read survives the data read. A second status register reports break frames and whether a reception is in progress.

Register map (2-bit address): 0 = received data (read), 1 = error status (read; writes are ignored), 2 = line status (read), 3 = control (read and write).

Top module: `uart_rx_err`

## Requirements
- R1: Each bit is the majority of its samples 7, 8 and 9, counted from 1 at the first tick that sees the line low in idle. The data bits are shifted in least significant bit first. After the stop bit is evaluated they appear at address 0.
- R2: The noise flag (address 1, bit 0) sets when samples 7, 8 and 9 disagree in any bit of an accepted frame, including its start, parity and stop bits.
- R3: The framing error flag (address 1, bit 1) sets when the stop bit votes 0.
- R4: With control bit 0 set, one parity bit follows the data. Control bit 1 selects odd parity when 1 and even parity when 0. The parity error flag (address 1, bit 2) sets when the data bits and the parity bit do not give the selected parity.
- R5: An error flag clears only when a read of address 1 that saw it set is followed by a read of address 0. A data read with no status read before it leaves the flags unchanged, and so does a write to address 1.
- R6: An error that occurs after the status read stays set after the next data read. This holds whether that flag was clear or already set at the status read.
- R7: irq_noise_o, irq_frame_o and irq_parity_o are each high exactly while their flag is set and their enable is set. The enables are control bits 2, 3 and 4.
- R8: Reset clears all error flags, both status registers and all interrupt requests.
- R9: Address 2 reads bit 1 = break: the last frame had all votes 0, stop bit included. It reads bit 0 = busy: high from the start edge until the stop bit is evaluated. Bits 7 to 2 read 0. The break bit is rewritten at the end of every frame.
- R10: A start bit whose vote is 1 is discarded. The receiver returns to idle, the data register and the flags are unchanged, and busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Enable pulse, 16 per bit time |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_noise_o | output | 1 | Noise interrupt request |
| irq_frame_o | output | 1 | Framing error interrupt request |
| irq_parity_o | output | 1 | Parity error interrupt request |

## Verification
The input is resynchronised through two flops, so the bench holds each line value for three clocks before it pulses the tick. This lets it name exactly which sample every level lands on, and lets it place a single-sample glitch on sample 8 of a chosen bit. The data, the error flags and the break bit update on the clock edge that takes sample 9 of the stop bit. The interrupt outputs follow the flags in that same cycle, and rdata_o is combinational. So every result is read back over the bus only after the frame task returns, which is several clocks past that edge. The side effect of a read takes place on the edge that ends the strobe, so each check on clearing is made by a later, separate read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_STAT  = 2'd1;
  localparam logic [1:0] A_STAT2 = 2'd2;
  localparam logic [1:0] A_CTRL  = 2'd3;

  localparam int E_NOISE  = 0;
  localparam int E_FRAME  = 1;
  localparam int E_PARITY = 2;
  localparam int NUM_ERR  = 3;

  localparam int REG_W = 8;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  output logic          rx_o,
  output logic          vote_o,
  output logic          noisy_o
);
  localparam int MID = (2 ** CW) / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
  end

  assign rx_o = sync_q[SYNC_STAGES-1];

  // samples 7 and 8 are held; sample 9 is the live value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 2'b11;
    else if (tick_i) begin
      if (cnt_i == CW'(MID - 2)) smp_q[0] <= rx_o;
      if (cnt_i == CW'(MID - 1)) smp_q[1] <= rx_o;
    end
  end

  assign vote_o  = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_o) | (smp_q[1] & rx_o);
  assign noisy_o = !((smp_q[0] == smp_q[1]) && (smp_q[1] == rx_o));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CW        = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  logic                 vote_i,
  input  logic                 noisy_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  output logic [CW-1:0]        cnt_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic [NUM_ERR-1:0]   err_o,
  output logic                 brk_o
);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] EVAL = CW'((2 ** CW) / 2);
  localparam logic [CW-1:0] LAST = CW'((2 ** CW) - 1);

  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 noise_q, zero_q, par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      noise_q <= 1'b0;
      zero_q  <= 1'b0;
      par_q   <= 1'b0;
    end else if (tick_i) begin
      if (state_q == ST_IDLE) begin
        if (!rx_i) begin
          state_q <= ST_START;
          cnt_q   <= CW'(1);
          bit_q   <= '0;
          noise_q <= 1'b0;
          zero_q  <= 1'b1;
          par_q   <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == EVAL) begin
          noise_q <= noise_q | noisy_i;
          case (state_q)
            ST_START: if (vote_i) state_q <= ST_IDLE;
            ST_DATA: begin
              shift_q <= {vote_i, shift_q[DATA_BITS-1:1]};
              par_q   <= par_q ^ vote_i;
              zero_q  <= zero_q & ~vote_i;
            end
            ST_PAR: begin
              par_q  <= par_q ^ vote_i;
              zero_q <= zero_q & ~vote_i;
            end
            ST_STOP: state_q <= ST_IDLE;
            default: ;
          endcase
        end
        if (cnt_q == LAST) begin
          case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
              if (bit_q == BW'(DATA_BITS - 1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else bit_q <= bit_q + 1'b1;
            end
            ST_PAR:  state_q <= ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = tick_i && (state_q == ST_STOP) && (cnt_q == EVAL);
  assign data_o = shift_q;
  assign err_o[E_NOISE]  = noise_q | noisy_i;
  assign err_o[E_FRAME]  = ~vote_i;
  assign err_o[E_PARITY] = par_en_i & (par_q ^ par_odd_i);
  assign brk_o  = zero_q & ~vote_i;

  AST_CNT_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R1
  AST_BREAK_IS_FRAME_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && brk_o) |-> err_o[E_FRAME]); // R9
  AST_FALSE_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_START && cnt_q == EVAL && vote_i) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic [NUM_ERR-1:0]   err_i,
  input  logic                 brk_i,
  input  logic                 busy_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [NUM_ERR-1:0]   irq_o,
  output logic                 par_en_o,
  output logic                 par_odd_o
);
  logic [REG_W-1:0]     ctrl_q;
  logic [DATA_BITS-1:0] data_q;
  logic [NUM_ERR-1:0]   flag_q, arm_q, set_ev, flag_n, arm_n;
  logic                 brk_q;
  logic                 rd_stat, rd_data;

  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign rd_data = rd_i && (addr_i == A_DATA);
  assign set_ev  = done_i ? err_i : '0;

  always_comb begin
    flag_n = (flag_q & ~(rd_data ? arm_q : '0)) | set_ev;
    if (rd_stat)      arm_n = flag_q;
    else if (rd_data) arm_n = '0;
    else              arm_n = arm_q;
    arm_n = arm_n & ~set_ev; // a fresh error must survive the next data read
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
      flag_q <= '0;
      arm_q  <= '0;
      brk_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
      if (done_i) begin
        data_q <= data_i;
        brk_q  <= brk_i;
      end
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = REG_W'(data_q);
      A_STAT:  rdata_o = REG_W'(flag_q);
      A_STAT2: rdata_o = {{(REG_W-2){1'b0}}, brk_q, busy_i};
      default: rdata_o = ctrl_q;
    endcase
  end

  assign irq_o     = flag_q & ctrl_q[2 +: NUM_ERR];
  assign par_en_o  = ctrl_q[0];
  assign par_odd_o = ctrl_q[1];

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag_chk
    AST_FLAG_RISE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> $past(done_i && err_i[i])); // R2
    AST_FLAG_FALL_ON_DATA_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q[i]) |-> $past(rd_data && arm_q[i])); // R5
    AST_NEW_ERROR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && err_i[i]) |=> flag_q[i]); // R6
  end
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR_LOG2  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             os_tick_i,
  input  logic             rxd_i,
  input  logic [1:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_noise_o,
  output logic             irq_frame_o,
  output logic             irq_parity_o
);
  logic [OSR_LOG2-1:0]  cnt;
  logic                 rx_s, vote, noisy, busy, done, brk, par_en, par_odd;
  logic [DATA_BITS-1:0] data;
  logic [NUM_ERR-1:0]   err, irq;

  uart_rx_sampler #(.SYNC_STAGES(SYNC_STAGES), .CW(OSR_LOG2)) i_sampler (
    .clk_i, .rst_ni, .rxd_i, .tick_i(os_tick_i), .cnt_i(cnt),
    .rx_o(rx_s), .vote_o(vote), .noisy_o(noisy)
  );

  uart_rx_frame #(.DATA_BITS(DATA_BITS), .CW(OSR_LOG2)) i_frame (
    .clk_i, .rst_ni, .tick_i(os_tick_i), .rx_i(rx_s), .vote_i(vote), .noisy_i(noisy),
    .par_en_i(par_en), .par_odd_i(par_odd), .cnt_o(cnt), .busy_o(busy),
    .done_o(done), .data_o(data), .err_o(err), .brk_o(brk)
  );

  uart_rx_regs #(.DATA_BITS(DATA_BITS)) i_regs (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i,
    .done_i(done), .data_i(data), .err_i(err), .brk_i(brk), .busy_i(busy),
    .rdata_o, .irq_o(irq), .par_en_o(par_en), .par_odd_o(par_odd)
  );

  assign irq_noise_o  = irq[E_NOISE];
  assign irq_frame_o  = irq[E_FRAME];
  assign irq_parity_o = irq[E_PARITY];

  AST_STAT2_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STAT2) |-> (rdata_o[REG_W-1:2] == '0)); // R9
  AST_IRQ_OFF_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !(irq_noise_o || irq_frame_o || irq_parity_o)); // R8
endmodule

// File: tb/test_uart_rx_err.sv
`timescale 1ns/1ps
module test_uart_rx_err;
  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       irq_n, irq_f, irq_p;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] probe_val;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  uart_rx_err i_uart_rx_err (
    .clk_i(clk), .rst_ni(rst_ni), .os_tick_i(tick), .rxd_i(rxd),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_noise_o(irq_n), .irq_frame_o(irq_f), .irq_parity_o(irq_p)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic sample(input logic val);
    rxd = val;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // n samples of val; sample 8 (index 7) inverted when flip is set
  task automatic send_bit(input logic val, input int n, input bit flip);
    for (int s = 0; s < n; s++) sample((flip && s == 7) ? ~val : val);
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // seq index: 0 start, 1..8 data, 9 parity when enabled, then stop
  task automatic send_frame(input logic [7:0] d, input bit pen, input logic pval,
                            input logic stopv, input int noise_at, input int probe_at);
    int idx = 0;
    send_bit(1'b0, 16, noise_at == idx);
    if (probe_at == idx) rd_reg(2'd2, probe_val);
    idx++;
    for (int b = 0; b < 8; b++) begin
      send_bit(d[b], 16, noise_at == idx);
      if (probe_at == idx) rd_reg(2'd2, probe_val);
      idx++;
    end
    if (pen) begin
      send_bit(pval, 16, noise_at == idx);
      idx++;
    end
    send_bit(stopv, 9, noise_at == idx);
    send_bit(1'b1, 6, 1'b0);
  endtask

  task automatic clear_all();
    logic [7:0] t;
    rd_reg(2'd1, t);
    rd_reg(2'd0, t);
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk("R8 irq during reset", {29'd0, irq_n, irq_f, irq_p}, 0);
    rst_ni = 1'b1;
    send_bit(1'b1, 4, 1'b0);
    rd_reg(2'd1, v); chk("R8 status after reset", v, 0);
    rd_reg(2'd2, v); chk("R8 status2 after reset", v, 0);

    // clean frame
    wr_reg(2'd3, 8'h00);
    send_frame(8'hA5, 0, 0, 1, -1, -1);
    rd_reg(2'd0, v); chk("R1 data clean", v, 8'hA5);
    rd_reg(2'd1, v); chk("R2 no flags clean", v, 0);
    rd_reg(2'd2, v); chk("R9 status2 idle", v, 0);

    // noise on data bit 3 (seq index 4)
    send_frame(8'h3C, 0, 0, 1, 4, -1);
    rd_reg(2'd1, v); chk("R2 noise flag", v, 8'h01);
    chk("R7 irq noise masked", irq_n, 0);
    wr_reg(2'd3, 8'h04);
    @(negedge clk); chk("R7 irq noise enabled", irq_n, 1);
    // status was just read: arm it away with a fresh clean status? no, use a plain data read now
    rd_reg(2'd0, v); chk("R1 majority data", v, 8'h3C);
    rd_reg(2'd1, v); chk("R5 flag after status then data", v, 8'h00);
    chk("R7 irq noise drops", irq_n, 0);

    // data read alone and status write do not clear
    send_frame(8'h11, 0, 0, 1, 0, -1);
    rd_reg(2'd0, v);
    wr_reg(2'd1, 8'h00);
    @(negedge clk); chk("R5 data read alone keeps flag", irq_n, 1);
    rd_reg(2'd1, v); chk("R5 status write ignored", v, 8'h01);
    rd_reg(2'd0, v);
    rd_reg(2'd1, v); chk("R5 cleared by sequence", v, 8'h00);

    // framing error
    wr_reg(2'd3, 8'h08);
    send_frame(8'h81, 0, 0, 0, -1, -1);
    chk("R7 irq frame", {30'd0, irq_f, irq_n}, 2'b10);
    rd_reg(2'd1, v); chk("R3 frame flag", v, 8'h02);
    // R6: noise arrives between status read and data read
    send_frame(8'h55, 0, 0, 1, 2, -1);
    rd_reg(2'd0, v); chk("R1 data after frame err", v, 8'h55);
    rd_reg(2'd1, v); chk("R6 new noise kept, frame cleared", v, 8'h01);
    // same flag set again after its status read
    send_frame(8'h66, 0, 0, 1, 9, -1);
    rd_reg(2'd0, v);
    rd_reg(2'd1, v); chk("R6 re-set noise kept", v, 8'h01);
    clear_all();
    rd_reg(2'd1, v); chk("R5 clean after clear", v, 8'h00);

    // parity, even then odd
    wr_reg(2'd3, 8'h11);
    send_frame(8'h07, 1, par_bit(8'h07, 0), 1, -1, -1);
    rd_reg(2'd1, v); chk("R4 even parity good", v, 8'h00);
    send_frame(8'h07, 1, ~par_bit(8'h07, 0), 1, -1, -1);
    chk("R7 irq parity", irq_p, 1);
    rd_reg(2'd1, v); chk("R4 even parity bad", v, 8'h04);
    rd_reg(2'd0, v); chk("R4 data with parity", v, 8'h07);
    wr_reg(2'd3, 8'h13);
    send_frame(8'h07, 1, par_bit(8'h07, 1), 1, -1, -1);
    rd_reg(2'd1, v); chk("R4 odd parity good", v, 8'h00);
    send_frame(8'h07, 1, ~par_bit(8'h07, 1), 1, -1, -1);
    rd_reg(2'd1, v); chk("R4 odd parity bad", v, 8'h04);
    rd_reg(2'd0, v);

    // break frame, then a normal one
    wr_reg(2'd3, 8'h00);
    send_frame(8'h00, 0, 0, 0, -1, -1);
    rd_reg(2'd2, v); chk("R9 break flag", v, 8'h02);
    rd_reg(2'd1, v); chk("R3 break is framing error", v, 8'h02);
    rd_reg(2'd0, v);
    send_frame(8'h42, 0, 0, 1, -1, 3);
    chk("R9 busy mid frame", probe_val, 8'h03);
    rd_reg(2'd2, v); chk("R9 break and busy cleared", v, 8'h00);

    // false start
    send_bit(1'b0, 6, 1'b0);
    send_bit(1'b1, 20, 1'b0);
    rd_reg(2'd2, v); chk("R10 idle after false start", v, 8'h00);
    rd_reg(2'd0, v); chk("R10 data unchanged", v, 8'h42);
    rd_reg(2'd1, v); chk("R10 flags unchanged", v, 8'h00);

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      bit pen, odd, good, nz;
      logic stopv, pv;
      int nat, len;
      d = 8'($urandom);
      pen = 1'($urandom); odd = 1'($urandom); good = ($urandom % 3) != 0;
      stopv = ($urandom % 4) != 0;
      len = pen ? 11 : 10;
      nz = ($urandom % 4) == 0;
      nat = nz ? int'($urandom % len) : -1;
      pv = good ? par_bit(d, odd) : ~par_bit(d, odd);
      wr_reg(2'd3, {6'd0, odd, pen});
      send_frame(d, pen, pv, stopv, nat, -1);
      rd_reg(2'd1, v);
      chk("R4 R3 R2 random flags", v,
          {5'd0, pen && !good, !stopv, nz});
      rd_reg(2'd0, v); chk("R1 random data", v, d);
      rd_reg(2'd1, v); chk("R5 random clear", v, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule